// File: doc/BRIEF.md
# PWM Pin Control with Fault Shutdown

This block sits between a PWM generator and a bank of output pads arranged as complementary pairs. Each pair has a high-side pin and a low-side pin. For every pin it chooses between two sources. One is the PWM waveform, shown at a selectable active level. The other is a general-purpose I/O value held in a port-data latch and a direction latch. A 3-bit enable code sets how many pairs carry PWM. A static configuration bit picks whether reset leaves all pins as general I/O or hands them all to the PWM.

An active-low fault pin, gated by a fault-enable bit, forces every PWM-driven pin to its inactive level through a purely combinational path. The inactive level is the opposite of the configured active level. A synchronized copy of the qualified fault drives a small trip state machine with three states:

- `ST_RUN`: normal operation.
- `ST_TRIPPED`: the sticky fault flag is set.
- `ST_REARM`: the flag has been cleared and the block is waiting for a PWM period boundary.

The transitions are:

- trip: `ST_RUN` to `ST_TRIPPED` on a synchronized fault.
- clear: `ST_TRIPPED` to `ST_REARM` on a clear request while the synchronized fault is low.
- re-trip: `ST_REARM` to `ST_TRIPPED` on a synchronized fault.
- resume: `ST_REARM` to `ST_RUN` on a period-start pulse with no fault.

PWM pins stay forced inactive in every state except `ST_RUN`.

Top module: `pwm_pin_ctrl`

## Requirements
- R1: With `cfg_boot_gpio`=1, reset loads enable code 0. Every pin is then general I/O, the direction latch resets to all ones (input, `pin_oe`=0), the port latch resets to 0, and `fault_flag` is 0.
- R2: With `cfg_boot_gpio`=0, reset loads enable code binary 100, and every pin is a PWM pin with `pin_oe`=1.
- R3: Pair p consists of pin 2p (high side) and pin 2p+1 (low side). Pair p carries PWM when the enable code is greater than p. Code 0 enables no pair, and codes of NUM_PAIRS or more enable every pair.
- R4: A pin that is not PWM-enabled drives `pin_out` from its port-latch bit and `pin_oe` as the inverse of its direction-latch bit (1 = input). Latch and enable-code writes with their strobes take effect after the next rising clock edge.
- R5: A PWM pin drives `pin_oe`=1 and shows its raw PWM bit unchanged when its active-level bit is 1, or inverted when it is 0. High-side pins use `cfg_hi_act` and low-side pins use `cfg_lo_act`.
- R6: While `fault_en`=1 and `fault_n`=0, every PWM pin drives the inverse of its active-level bit in the same cycle, with no clock edge needed. General I/O pins are unaffected.
- R7: While `fault_en`=0, `fault_n` has no effect on any pin, and `fault_flag` stays 0.
- R8: An enabled fault sets `fault_flag` after the third rising edge counted from its assertion. The flag stays set after the fault pin is released.
- R9: A `fault_clr` pulse clears `fault_flag` only when the synchronized fault is deasserted. A pulse while the fault is still present is ignored.
- R10: After a clear, PWM pins stay forced inactive until a `period_start` pulse is seen in a later cycle. A synchronized fault in the same cycle as that pulse wins and re-trips the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_boot_gpio | input | 1 | Reset mode: 1 = all pins general I/O, 0 = all pins PWM |
| cfg_hi_act | input | 1 | Active level of high-side PWM pins |
| cfg_lo_act | input | 1 | Active level of low-side PWM pins |
| en_we | input | 1 | Write strobe for the enable code |
| en_wdata | input | 3 | New enable code |
| port_we | input | 1 | Write strobe for the port-data latch |
| port_wdata | input | 2*NUM_PAIRS | New port-data latch value |
| dir_we | input | 1 | Write strobe for the direction latch |
| dir_wdata | input | 2*NUM_PAIRS | New direction latch value (1 = input) |
| pwm_hi | input | NUM_PAIRS | Raw high-side PWM signals |
| pwm_lo | input | NUM_PAIRS | Raw low-side PWM signals |
| period_start | input | 1 | PWM period boundary pulse |
| fault_n | input | 1 | Active-low fault pin |
| fault_en | input | 1 | Fault input enable |
| fault_clr | input | 1 | Request to clear the fault flag |
| pin_out | output | 2*NUM_PAIRS | Pin drive values |
| pin_oe | output | 2*NUM_PAIRS | Pin output enables |
| fault_flag | output | 1 | Sticky fault status |

## Verification
Two functions can fall in the same cycle: the period boundary that resumes PWM and a fresh fault that re-trips the block. The bench provokes this by clearing the flag and then asserting the fault pin. After two edges, when the synchronized fault is about to reach the state machine, it pulses `period_start`. The result is judged by `fault_flag` reading 1 and the PWM pins staying inactive after the pin is released. A second collision puts a clear request and a boundary in the same cycle, and the pins must stay forced until a later boundary.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
    localparam int EN_CODE_W = 3;
    localparam logic [EN_CODE_W-1:0] EN_ALL_CODE = 3'b100;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_TRIPPED = 2'd1,
        ST_REARM   = 2'd2
    } trip_state_t;
endpackage

// File: rtl/pwm_pin_sync.sv
module pwm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_pin_trip_fsm.sv
module pwm_pin_trip_fsm
    import pwm_pin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fault_seen,
    input  logic        clear_req,
    input  logic        period_start,
    output trip_state_t state,
    output logic        flag,
    output logic        hold_off
);
    trip_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fault_seen) state_d = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (clear_req && !fault_seen) state_d = ST_REARM;
            end
            ST_REARM: begin
                if (fault_seen)        state_d = ST_TRIPPED;
                else if (period_start) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        flag     = 1'b0;
        hold_off = 1'b1;
        unique case (state_q)
            ST_RUN:     hold_off = 1'b0;
            ST_TRIPPED: flag     = 1'b1;
            ST_REARM:   flag     = 1'b0;
            default:    hold_off = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pwm_pin_cell.sv
module pwm_pin_cell (
    input  logic pwm_raw,
    input  logic act_level,
    input  logic pwm_sel,
    input  logic force_off,
    input  logic port_bit,
    input  logic dir_in,
    output logic pad_out,
    output logic pad_oe
);
    always_comb begin
        if (pwm_sel) begin
            pad_oe  = 1'b1;
            pad_out = force_off ? ~act_level : (act_level ? pwm_raw : ~pwm_raw);
        end else begin
            pad_oe  = ~dir_in;
            pad_out = port_bit;
        end
    end
endmodule

// File: rtl/pwm_pin_ctrl.sv
module pwm_pin_ctrl
    import pwm_pin_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_boot_gpio,
    input  logic                   cfg_hi_act,
    input  logic                   cfg_lo_act,
    input  logic                   en_we,
    input  logic [2:0]             en_wdata,
    input  logic                   port_we,
    input  logic [2*NUM_PAIRS-1:0] port_wdata,
    input  logic                   dir_we,
    input  logic [2*NUM_PAIRS-1:0] dir_wdata,
    input  logic [NUM_PAIRS-1:0]   pwm_hi,
    input  logic [NUM_PAIRS-1:0]   pwm_lo,
    input  logic                   period_start,
    input  logic                   fault_n,
    input  logic                   fault_en,
    input  logic                   fault_clr,
    output logic [2*NUM_PAIRS-1:0] pin_out,
    output logic [2*NUM_PAIRS-1:0] pin_oe,
    output logic                   fault_flag
);
    localparam int NUM_PINS = 2 * NUM_PAIRS;

    logic [EN_CODE_W-1:0] en_code_q;
    logic [NUM_PINS-1:0]  port_q;
    logic [NUM_PINS-1:0]  dir_q;
    logic                 fault_live;
    logic                 fault_raw_s;
    logic                 fault_qual_s;
    logic                 hold_off;
    logic                 force_off;
    trip_state_t          trip_state;

    // Control latches; the enable code reset value is chosen by the boot mode bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_code_q <= cfg_boot_gpio ? '0 : EN_ALL_CODE;
            port_q    <= '0;
            dir_q     <= '1;
        end else begin
            if (en_we)   en_code_q <= en_wdata;
            if (port_we) port_q    <= port_wdata;
            if (dir_we)  dir_q     <= dir_wdata;
        end
    end

    // Unsynchronized qualified fault: drives the shutdown with no clock in the path.
    assign fault_live = fault_en & ~fault_n;

    pwm_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_fault_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~fault_n),
        .q     (fault_raw_s)
    );

    assign fault_qual_s = fault_en & fault_raw_s;

    pwm_pin_trip_fsm u_trip (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_seen   (fault_qual_s),
        .clear_req    (fault_clr),
        .period_start (period_start),
        .state        (trip_state),
        .flag         (fault_flag),
        .hold_off     (hold_off)
    );

    assign force_off = fault_live | hold_off;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic pair_sel;
        assign pair_sel = (int'(en_code_q) > p);

        pwm_pin_cell u_hi (
            .pwm_raw   (pwm_hi[p]),
            .act_level (cfg_hi_act),
            .pwm_sel   (pair_sel),
            .force_off (force_off),
            .port_bit  (port_q[2*p]),
            .dir_in    (dir_q[2*p]),
            .pad_out   (pin_out[2*p]),
            .pad_oe    (pin_oe[2*p])
        );

        pwm_pin_cell u_lo (
            .pwm_raw   (pwm_lo[p]),
            .act_level (cfg_lo_act),
            .pwm_sel   (pair_sel),
            .force_off (force_off),
            .port_bit  (port_q[2*p+1]),
            .dir_in    (dir_q[2*p+1]),
            .pad_out   (pin_out[2*p+1]),
            .pad_oe    (pin_oe[2*p+1])
        );
    end
endmodule

// File: rtl/pwm_pin_ctrl_checker.sv
module pwm_pin_ctrl_checker
    import pwm_pin_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fault_en,
    input logic                   fault_n,
    input logic                   fault_clr,
    input logic                   period_start,
    input logic                   cfg_hi_act,
    input logic                   cfg_lo_act,
    input logic [EN_CODE_W-1:0]   en_code_q,
    input logic [2*NUM_PAIRS-1:0] port_q,
    input logic [2*NUM_PAIRS-1:0] dir_q,
    input logic                   fault_qual_s,
    input trip_state_t            trip_state,
    input logic [2*NUM_PAIRS-1:0] pin_out,
    input logic [2*NUM_PAIRS-1:0] pin_oe,
    input logic                   fault_flag
);
    localparam int NPINS = 2 * NUM_PAIRS;

    logic [NPINS-1:0] pwm_mask;
    logic [NPINS-1:0] idle_lvl;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            pwm_mask[i] = (int'(en_code_q) > (i / 2));
            idle_lvl[i] = (i % 2 == 0) ? ~cfg_hi_act : ~cfg_lo_act;
        end
    end

    assert_fault_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_en && !fault_n) |->
            (((pin_out & pwm_mask) == (idle_lvl & pwm_mask)) && ((pin_oe & pwm_mask) == pwm_mask)));

    assert_gpio_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pwm_mask) == (port_q & ~pwm_mask)) &&
        ((pin_oe & ~pwm_mask) == (~dir_q & ~pwm_mask)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag);

    assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && fault_qual_s) |=> fault_flag);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_flag && !fault_en) |=> !fault_flag);

    assert_rearm_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_state == ST_REARM && !period_start && !fault_qual_s) |=> (trip_state == ST_REARM));
endmodule

bind pwm_pin_ctrl pwm_pin_ctrl_checker #(
    .NUM_PAIRS (NUM_PAIRS)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_en     (fault_en),
    .fault_n      (fault_n),
    .fault_clr    (fault_clr),
    .period_start (period_start),
    .cfg_hi_act   (cfg_hi_act),
    .cfg_lo_act   (cfg_lo_act),
    .en_code_q    (en_code_q),
    .port_q       (port_q),
    .dir_q        (dir_q),
    .fault_qual_s (fault_qual_s),
    .trip_state   (trip_state),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .fault_flag   (fault_flag)
);

// File: tb/pwm_pin_ctrl_test.sv
module pwm_pin_ctrl_test;
    localparam int NPAIR = 4;
    localparam int NPIN  = 2 * NPAIR;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n, cfg_boot_gpio, cfg_hi_act, cfg_lo_act;
    logic            en_we, port_we, dir_we;
    logic [2:0]      en_wdata;
    logic [NPIN-1:0] port_wdata, dir_wdata;
    logic [NPAIR-1:0] pwm_hi, pwm_lo;
    logic            period_start, fault_n, fault_en, fault_clr;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic            fault_flag;

    int tests = 0;
    int fails = 0;

    logic [2:0]      s_code;
    logic [NPIN-1:0] s_port, s_dir;

    pwm_pin_ctrl #(.NUM_PAIRS(NPAIR)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_boot_gpio(cfg_boot_gpio),
        .cfg_hi_act(cfg_hi_act), .cfg_lo_act(cfg_lo_act),
        .en_we(en_we), .en_wdata(en_wdata),
        .port_we(port_we), .port_wdata(port_wdata),
        .dir_we(dir_we), .dir_wdata(dir_wdata),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .period_start(period_start),
        .fault_n(fault_n), .fault_en(fault_en), .fault_clr(fault_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .fault_flag(fault_flag)
    );

    function automatic logic [2*NPIN-1:0] model(input logic [2:0] code,
                                                input logic [NPIN-1:0] port, dir,
                                                input logic [NPAIR-1:0] hi, lo,
                                                input logic ph, pl, forced);
        logic [NPIN-1:0] o, e;
        for (int i = 0; i < NPIN; i++) begin
            int   p;
            logic act, raw;
            p   = i / 2;
            act = (i % 2 == 0) ? ph : pl;
            raw = (i % 2 == 0) ? hi[p] : lo[p];
            if (int'(code) > p) begin
                e[i] = 1'b1;
                o[i] = forced ? ~act : (act ? raw : ~raw);
            end else begin
                e[i] = ~dir[i];
                o[i] = port[i];
            end
        end
        return {e, o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input logic forced);
        check(req, 32'({pin_oe, pin_out}),
              32'(model(s_code, s_port, s_dir, pwm_hi, pwm_lo, cfg_hi_act, cfg_lo_act, forced)));
    endtask

    task automatic do_reset(input logic boot_gpio);
        cfg_boot_gpio = boot_gpio;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        s_code = boot_gpio ? 3'd0 : 3'b100;
        s_port = '0;
        s_dir  = '1;
    endtask

    task automatic wr_all(input logic [2:0] c, input logic [NPIN-1:0] p, input logic [NPIN-1:0] d);
        @(negedge clk);
        en_we = 1'b1; en_wdata = c;
        port_we = 1'b1; port_wdata = p;
        dir_we = 1'b1; dir_wdata = d;
        @(negedge clk);
        en_we = 1'b0; port_we = 1'b0; dir_we = 1'b0;
        s_code = c; s_port = p; s_dir = d;
    endtask

    task automatic pulse_clr();
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst_n = 1'b0; cfg_boot_gpio = 1'b1; cfg_hi_act = 1'b1; cfg_lo_act = 1'b1;
        en_we = 0; port_we = 0; dir_we = 0; en_wdata = '0; port_wdata = '0; dir_wdata = '0;
        pwm_hi = '0; pwm_lo = '0; period_start = 0; fault_n = 1; fault_en = 0; fault_clr = 0;

        // R1: boot into general I/O
        do_reset(1'b1);
        @(negedge clk); #1;
        check("R1 oe", 32'(pin_oe), 32'(0));
        check("R1 out", 32'(pin_out), 32'(0));
        check("R1 flag", 32'(fault_flag), 32'(0));
        pwm_hi = 4'hF; pwm_lo = 4'hA; #1;
        check_pins("R1 pwm ignored", 1'b0);

        // R2: boot into PWM on every pair
        cfg_hi_act = 1'b1; cfg_lo_act = 1'b0;
        do_reset(1'b0);
        pwm_hi = 4'b1001; pwm_lo = 4'b0110;
        @(negedge clk); #1;
        check("R2 oe", 32'(pin_oe), 32'({NPIN{1'b1}}));
        check_pins("R2 drive", 1'b0);

        // R3 R4 R5 R7: random mix with the fault input disabled
        for (int n = 0; n < 60; n++) begin
            wr_all(3'($urandom), NPIN'($urandom), NPIN'($urandom));
            pwm_hi = NPAIR'($urandom); pwm_lo = NPAIR'($urandom);
            cfg_hi_act = 1'($urandom); cfg_lo_act = 1'($urandom);
            fault_en = 1'b0; fault_n = 1'($urandom);
            #1;
            check_pins("R3 R4 R5 R7 random", 1'b0);
            check("R7 flag stays low", 32'(fault_flag), 32'(0));
        end
        fault_n = 1'b1;

        // R3: every enable code
        cfg_hi_act = 1'b1; cfg_lo_act = 1'b0;
        pwm_hi = 4'b1010; pwm_lo = 4'b0110;
        for (int c = 0; c < 8; c++) begin
            wr_all(3'(c), 8'hA5, 8'h3C);
            #1;
            check_pins("R3 code sweep", 1'b0);
        end

        // R6 R8: enabled fault, two PWM pairs and two I/O pairs
        wr_all(3'd2, 8'hF0, 8'h0F);
        pwm_hi = 4'hF; pwm_lo = 4'h0;
        fault_en = 1'b1;
        @(negedge clk);
        fault_n = 1'b0; #1;
        check_pins("R6 immediate shutdown", 1'b1);
        check("R8 flag not yet", 32'(fault_flag), 32'(0));
        @(negedge clk); @(negedge clk); #1;
        check("R8 flag after two edges", 32'(fault_flag), 32'(0));
        @(negedge clk); #1;
        check("R8 flag after three edges", 32'(fault_flag), 32'(1));

        // R9: clear while fault present is ignored
        pulse_clr();
        check("R9 clear blocked", 32'(fault_flag), 32'(1));

        // R8 R10: release the pin, flag and shutdown hold
        fault_n = 1'b1;
        repeat (3) @(negedge clk); #1;
        check("R8 sticky", 32'(fault_flag), 32'(1));
        check_pins("R10 held while tripped", 1'b1);

        pulse_clr();
        check("R9 clear accepted", 32'(fault_flag), 32'(0));
        check_pins("R10 forced until boundary", 1'b1);
        repeat (3) @(negedge clk); #1;
        check_pins("R10 still waiting", 1'b1);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0; #1;
        check_pins("R10 resume at boundary", 1'b0);
        pwm_hi = 4'h5; pwm_lo = 4'hC; #1;
        check_pins("R5 after resume", 1'b0);

        // R10: boundary collides with a fresh fault in the rearm state
        fault_n = 1'b0;
        repeat (3) @(negedge clk);
        fault_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse_clr();
        check("R9 rearm entered", 32'(fault_flag), 32'(0));
        @(negedge clk);
        fault_n = 1'b0;
        @(negedge clk); @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0; #1;
        check("R10 fault wins over boundary", 32'(fault_flag), 32'(1));
        fault_n = 1'b1;
        repeat (3) @(negedge clk); #1;
        check_pins("R10 retripped stays forced", 1'b1);

        // R10: boundary in the clearing cycle does not resume
        fault_clr = 1'b1; period_start = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0; period_start = 1'b0; #1;
        check("R10 cleared with boundary", 32'(fault_flag), 32'(0));
        check_pins("R10 boundary in clear cycle", 1'b1);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0; #1;
        check_pins("R10 later boundary resumes", 1'b0);

        // R7: disabled fault input held low
        fault_en = 1'b0; fault_n = 1'b0;
        repeat (5) @(negedge clk); #1;
        check("R7 flag disabled", 32'(fault_flag), 32'(0));
        check_pins("R7 pins disabled", 1'b0);
        fault_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule